// File: doc/BRIEF.md
# Serial Receive Queue with Holding Register

This block turns an asynchronous serial input into characters and places them in a 16-entry receive queue. Each character carries three tags: framing error, parity error and break. The CPU side always sees the oldest queued character with its tags on the head outputs. A one-cycle read strobe removes that character. Status outputs report whether data is waiting, whether the queue is full, whether a character was lost, and whether the break state changed.

The line is sampled on a clock enable that runs at sixteen times the bit rate. Character length (5 to 8 bits) and parity (none, even or odd) are set by static configuration inputs. When the queue is full, one finished character waits in a holding register. The next read moves it into the queue at once, so the full flag drops only on the second read. If yet another character finishes while one is already waiting, the waiting character and its tags are discarded and the lost-data flag is raised. A break occupies exactly one queue entry. The receiver then stays silent until the line has returned high.

Top module: `serq_rx_top`

## Requirements
- R1: After reset, rxReady, rxFull, overrun and breakChange are all 0.
- R2: Data bits arrive LSB first after the start bit. The length is set by cfgDataBits: 00=5, 01=6, 10=7, 11=8 bits. The character appears right-aligned on rdData with unused upper bits at 0.
- R3: With cfgParityEn=1, one parity bit follows the data. rdParityErr is 1 when the ones in data plus parity bit are odd and cfgParityOdd=0, or even and cfgParityOdd=1. With cfgParityEn=0, rdParityErr is 0.
- R4: The stop bit is sampled in the middle of its first bit period. A low sample on a character that is not a break sets rdFrameErr for that character.
- R5: A low level on rxLine that is high again at mid start bit (8 sample ticks after detection) produces no character.
- R6: Characters leave in arrival order. rxReady is 1 exactly while at least one character is queued, so a read that leaves entries behind keeps it at 1.
- R7: rxFull is 1 while all 16 entries are occupied. A character that completes while the queue is full waits, and one read refills the queue from it, so rxFull stays 1 until the second read.
- R8: A character that completes while the queue is full and one is already waiting replaces the waiting one, which is lost. overrun is set and stays 1 until a clrErrCmd pulse.
- R9: A character of all zero data bits, a zero parity bit (when enabled) and a low stop sample is a break. It is stored as one entry with rdData=0, rdBreak=1, rdFrameErr=0 and rdParityErr=0. No further entries are made until rxLine has been high for 8 consecutive sample ticks.
- R10: breakChange is set when a break is detected and again when the line has been high for 8 consecutive sample ticks after a break. It stays set until a clrBrkChgCmd pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Enable at sixteen times the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| cfgDataBits | input | 2 | Character length code (00=5 .. 11=8) |
| cfgParityEn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even |
| rdStrobe | input | 1 | Removes the head character |
| clrErrCmd | input | 1 | Clears the overrun flag |
| clrBrkChgCmd | input | 1 | Clears the break-change flag |
| rdData | output | 8 | Head character data |
| rdFrameErr | output | 1 | Head framing-error tag |
| rdParityErr | output | 1 | Head parity-error tag |
| rdBreak | output | 1 | Head break tag |
| rxReady | output | 1 | At least one character queued |
| rxFull | output | 1 | All entries occupied |
| overrun | output | 1 | A character was lost |
| breakChange | output | 1 | Break began or ended |

## Verification
A wrong queue count shows as rxReady or rxFull at the wrong level within one cycle of the push or read that caused it. A mishandled holding register shows either as rxFull dropping on the first read after a full queue, or as a wrong character order at the head during the drain that follows. A bit-timing or parity fault shows on the head tags of the very character concerned. A break fault shows as an extra queue entry or a missing breakChange edge within one bit time of the line returning high.

// File: rtl/serq_pkg.sv
`timescale 1ns/1ps
package serq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic     charDone;
    logic     brkEnd;
    rxEntry_t ent;
  } rxStrobe_t;
endpackage

// File: rtl/serq_rx_ctrl.sv
`timescale 1ns/1ps
module serq_rx_ctrl
  import serq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParityEn,
  input  logic       cfgParityOdd,
  output rxStrobe_t  strb
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKWAIT
  } rxState_t;

  rxState_t          state;
  logic [1:0]        rxSync;
  logic              rxS;
  logic [CNT_W-1:0]  tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              parErr;
  logic              isBreak;

  assign rxS     = rxSync[1];
  assign lastIdx = IDX_W'(DATA_W - 4) + IDX_W'(cfgDataBits);
  assign parErr  = cfgParityEn & (^shreg ^ pbit ^ cfgParityOdd);
  assign isBreak = (shreg == '0) && !(cfgParityEn && pbit) && !rxS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rxSync  <= '1;
      tickCnt <= '0;
      bitIdx  <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      strb    <= '0;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      strb   <= '0;
      if (sampleTick) begin
        case (state)
          S_IDLE: begin
            if (!rxS) begin
              state   <= S_START;
              tickCnt <= '0;
            end
          end
          S_START: begin
            if (tickCnt == MID_TICK) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              shreg   <= '0;
              pbit    <= 1'b0;
              state   <= rxS ? S_IDLE : S_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_DATA: begin
            if (tickCnt == LAST_TICK) begin
              tickCnt        <= '0;
              shreg[bitIdx]  <= rxS;
              if (bitIdx == lastIdx) state <= cfgParityEn ? S_PAR : S_STOP;
              else                   bitIdx <= bitIdx + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_PAR: begin
            if (tickCnt == LAST_TICK) begin
              tickCnt <= '0;
              pbit    <= rxS;
              state   <= S_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_STOP: begin
            if (tickCnt == LAST_TICK) begin
              tickCnt           <= '0;
              strb.charDone     <= 1'b1;
              strb.ent.data     <= shreg;
              strb.ent.brk      <= isBreak;
              strb.ent.fe       <= !rxS && !isBreak;
              strb.ent.pe       <= parErr && !isBreak;
              state             <= isBreak ? S_BRKWAIT : S_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_BRKWAIT: begin
            if (!rxS) begin
              tickCnt <= '0;
            end else if (tickCnt == MID_TICK) begin
              tickCnt     <= '0;
              strb.brkEnd <= 1'b1;
              state       <= S_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serq_rx_queue.sv
`timescale 1ns/1ps
module serq_rx_queue
  import serq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              rdStrobe,
  input  logic              clrErrCmd,
  input  logic              clrBrkChgCmd,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFrameErr,
  output logic              rdParityErr,
  output logic              rdBreak,
  output logic              rxReady,
  output logic              rxFull,
  output logic              overrun,
  output logic              breakChange
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  rxEntry_t        mem [DEPTH];
  rxEntry_t        hold;
  rxEntry_t        pushEnt;
  rxEntry_t        headEnt;
  logic            holdV;
  logic [AW-1:0]   wrPtr, rdPtr;
  logic [CW-1:0]   count;
  logic            pop, space, pushEn, holdLoad, ovrSet;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign pop   = rdStrobe && (count != '0);
  assign space = (count != FULL_CNT) || pop;

  always_comb begin
    pushEn   = 1'b0;
    pushEnt  = strb.ent;
    holdLoad = 1'b0;
    ovrSet   = 1'b0;
    if (holdV) begin
      if (space) begin
        pushEn  = 1'b1;
        pushEnt = hold;
      end
      if (strb.charDone) begin
        holdLoad = 1'b1;
        ovrSet   = !space;
      end
    end else if (strb.charDone) begin
      if (space) pushEn   = 1'b1;
      else       holdLoad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushEnt;
    if (holdLoad) hold <= strb.ent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      count       <= '0;
      holdV       <= 1'b0;
      overrun     <= 1'b0;
      breakChange <= 1'b0;
    end else begin
      if (pushEn) wrPtr <= nextPtr(wrPtr);
      if (pop)    rdPtr <= nextPtr(rdPtr);
      case ({pushEn, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      holdV       <= holdLoad || (holdV && !space);
      overrun     <= (overrun && !clrErrCmd) || ovrSet;
      breakChange <= (breakChange && !clrBrkChgCmd)
                   || (strb.charDone && strb.ent.brk) || strb.brkEnd;
    end
  end

  assign headEnt     = mem[rdPtr];
  assign rdData      = headEnt.data;
  assign rdFrameErr  = headEnt.fe;
  assign rdParityErr = headEnt.pe;
  assign rdBreak     = headEnt.brk;
  assign rxReady     = (count != '0);
  assign rxFull      = (count == FULL_CNT);
endmodule

// File: rtl/serq_rx_top.sv
`timescale 1ns/1ps
module serq_rx_top
  import serq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParityEn,
  input  logic       cfgParityOdd,
  input  logic       rdStrobe,
  input  logic       clrErrCmd,
  input  logic       clrBrkChgCmd,
  output logic [7:0] rdData,
  output logic       rdFrameErr,
  output logic       rdParityErr,
  output logic       rdBreak,
  output logic       rxReady,
  output logic       rxFull,
  output logic       overrun,
  output logic       breakChange
);
  rxStrobe_t strb;

  serq_rx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .strb(strb)
  );

  serq_rx_queue #(.DEPTH(FIFO_DEPTH)) queue_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdStrobe(rdStrobe),
    .clrErrCmd(clrErrCmd), .clrBrkChgCmd(clrBrkChgCmd),
    .rdData(rdData), .rdFrameErr(rdFrameErr), .rdParityErr(rdParityErr),
    .rdBreak(rdBreak), .rxReady(rxReady), .rxFull(rxFull),
    .overrun(overrun), .breakChange(breakChange)
  );
endmodule

// File: rtl/serq_chk.sv
`timescale 1ns/1ps
module serq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdStrobe,
  input logic       clrErrCmd,
  input logic       clrBrkChgCmd,
  input logic [7:0] rdData,
  input logic       rdFrameErr,
  input logic       rdBreak,
  input logic       rxReady,
  input logic       rxFull,
  input logic       overrun,
  input logic       breakChange
);
  a_r7_full_implies_ready: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> rxReady);

  a_r7_full_kept_without_read: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rdStrobe) |=> rxFull);

  a_r6_ready_kept_without_read: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !rdStrobe) |=> rxReady);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrErrCmd) |=> overrun);

  a_r10_brkchg_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (breakChange && !clrBrkChgCmd) |=> breakChange);

  a_r9_break_entry_clean: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && rdBreak) |-> (rdData == 8'h00 && !rdFrameErr));
endmodule

bind serq_rx_top serq_chk chk_i (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .clrErrCmd(clrErrCmd),
  .clrBrkChgCmd(clrBrkChgCmd), .rdData(rdData), .rdFrameErr(rdFrameErr),
  .rdBreak(rdBreak), .rxReady(rxReady), .rxFull(rxFull),
  .overrun(overrun), .breakChange(breakChange)
);

// File: tb/serq_rx_top_tb_top.sv
`timescale 1ns/1ps
module serq_rx_top_tb_top;
  localparam int BITCLK = 64;
  localparam int QDEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] cfgDataBits = 2'b11;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       clrErrCmd = 1'b0;
  logic       clrBrkChgCmd = 1'b0;
  logic [7:0] rdData;
  logic       rdFrameErr, rdParityErr, rdBreak;
  logic       rxReady, rxFull, overrun, breakChange;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [10:0] expQ[$];
  logic [10:0] expHold;
  bit          expHoldV = 0;
  bit          expOvr = 0;

  serq_rx_top dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .rdStrobe(rdStrobe), .clrErrCmd(clrErrCmd),
    .clrBrkChgCmd(clrBrkChgCmd), .rdData(rdData), .rdFrameErr(rdFrameErr),
    .rdParityErr(rdParityErr), .rdBreak(rdBreak), .rxReady(rxReady),
    .rxFull(rxFull), .overrun(overrun), .breakChange(breakChange)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      sampleTick = 1'b1;
      @(negedge clk);
      sampleTick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskData(input logic [7:0] d, input logic [1:0] lc);
    return d & 8'((9'h1 << (5 + lc)) - 1);
  endfunction

  function automatic logic [10:0] expEntry(input logic [7:0] d, input logic [1:0] lc,
                                           input bit pe, input bit badPar, input bit badStop);
    return {1'b0, badStop, pe & badPar, maskData(d, lc)};
  endfunction

  task automatic modelPush(input logic [10:0] e);
    if (expQ.size() < QDEPTH) expQ.push_back(e);
    else begin
      if (expHoldV) expOvr = 1;
      expHold  = e;
      expHoldV = 1;
    end
  endtask

  task automatic bitHold(input logic v);
    rxLine = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input bit badPar, input bit badStop);
    logic [7:0] dm;
    logic p;
    dm = maskData(d, cfgDataBits);
    bitHold(1'b0);
    for (int i = 0; i < 5 + int'(cfgDataBits); i++) bitHold(dm[i]);
    if (cfgParityEn) begin
      p = ^dm ^ cfgParityOdd ^ badPar;
      bitHold(p);
    end
    bitHold(!badStop);
    bitHold(1'b1);
    bitHold(1'b1);
    modelPush(expEntry(d, cfgDataBits, cfgParityEn, badPar, badStop));
  endtask

  task automatic checkStatus(input string req);
    chk({req, " rxReady"}, 32'(rxReady), 32'(expQ.size() != 0));
    chk({req, " rxFull"},  32'(rxFull),  32'(expQ.size() == QDEPTH));
    chk({req, " overrun"}, 32'(overrun), 32'(expOvr));
  endtask

  task automatic doRead(input string req);
    logic [10:0] e;
    e = expQ.pop_front();
    chk({req, " head"}, 32'({rdBreak, rdFrameErr, rdParityErr, rdData}), 32'(e));
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    if (expHoldV) begin
      expQ.push_back(expHold);
      expHoldV = 0;
    end
    @(negedge clk);
  endtask

  task automatic pulseClr(input bit err, input bit brk);
    clrErrCmd = err;
    clrBrkChgCmd = brk;
    @(negedge clk);
    clrErrCmd = 1'b0;
    clrBrkChgCmd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'h0000_5eed);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rxReady", 32'(rxReady), 0);
    chk("R1 rxFull", 32'(rxFull), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 breakChange", 32'(breakChange), 0);

    // R5 glitch shorter than half a bit
    rxLine = 1'b0;
    repeat (12) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk("R5 no char from glitch", 32'(rxReady), 0);

    // R2 directed lengths, R4 framing, R3 parity
    cfgDataBits = 2'b00; sendChar(8'hFF, 0, 0); checkStatus("R2 len5");
    doRead("R2 len5 masked");
    cfgDataBits = 2'b10; sendChar(8'h55, 0, 1); doRead("R4 framing tag");
    cfgDataBits = 2'b11; cfgParityEn = 1; cfgParityOdd = 0;
    sendChar(8'hA7, 1, 0); doRead("R3 even bad");
    cfgParityOdd = 1; sendChar(8'h3C, 0, 0); doRead("R3 odd good");
    cfgParityOdd = 1; sendChar(8'h3C, 1, 0); doRead("R3 odd bad");

    // R6 order and rxReady after partial read
    cfgParityEn = 0;
    sendChar(8'h11, 0, 0); sendChar(8'h22, 0, 0);
    doRead("R6 first"); checkStatus("R6 one left");
    doRead("R6 second"); checkStatus("R6 empty");

    // R2 R3 R4 random mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d;
      bit bp, bs;
      cfgDataBits  = 2'($urandom_range(0, 3));
      cfgParityEn  = 1'($urandom_range(0, 1));
      cfgParityOdd = 1'($urandom_range(0, 1));
      d  = 8'($urandom);
      bp = cfgParityEn && ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 4) == 0) && (maskData(d, cfgDataBits) != 0);
      sendChar(d, bp, bs);
      if ((n % 3) == 2) begin
        while (expQ.size() != 0) doRead("R2 R3 R4 random");
      end
    end
    while (expQ.size() != 0) doRead("R6 drain");
    checkStatus("R6 drained");

    // R7 full and holding register
    cfgDataBits = 2'b11; cfgParityEn = 0;
    for (int n = 0; n < QDEPTH; n++) begin
      sendChar(8'(8'h40 + n), 0, 0);
      if (n == QDEPTH - 2) checkStatus("R7 one short of full");
    end
    checkStatus("R7 full");
    sendChar(8'h99, 0, 0);
    checkStatus("R7 waiting char");
    doRead("R7 read one");
    chk("R7 still full after first read", 32'(rxFull), 1);
    doRead("R7 read two");
    chk("R7 clears after second read", 32'(rxFull), 0);
    while (expQ.size() != 0) doRead("R7 drain");

    // R8 overrun
    for (int n = 0; n < QDEPTH + 2; n++) sendChar(8'(8'h80 + n), 0, 0);
    checkStatus("R8 overrun set");
    while (expQ.size() != 0) doRead("R8 order after loss");
    chk("R8 overrun sticky", 32'(overrun), 1);
    pulseClr(1, 0);
    expOvr = 0;
    chk("R8 cleared", 32'(overrun), 0);

    // R9 R10 break
    rxLine = 1'b0;
    repeat (12 * BITCLK) @(negedge clk);
    expQ.push_back(11'h400);
    chk("R10 break start flag", 32'(breakChange), 1);
    checkStatus("R9 single entry");
    pulseClr(0, 1);
    chk("R10 cleared", 32'(breakChange), 0);
    repeat (6 * BITCLK) @(negedge clk);
    chk("R9 no extra entry while low", 32'(breakChange), 0);
    rxLine = 1'b1;
    repeat (BITCLK) @(negedge clk);
    chk("R10 break end flag", 32'(breakChange), 1);
    doRead("R9 break entry");
    chk("R9 only one entry", 32'(rxReady), 0);
    sendChar(8'h5A, 0, 0);
    doRead("R9 receiver resumes");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule